// File: doc/BRIEF.md
# Single-Digit Decimal Counter with Seven-Segment Output

This block shows one decimal digit on a seven-segment display. It runs from a fast board clock, by default 12 MHz. A prescaler counts clock cycles and produces a one-cycle enable pulse every `DIV_RATIO` cycles. The default ratio gives roughly one count per second, slow enough for a person to follow. There is no second clock domain: the whole block runs on the board clock.

On each enable pulse the digit moves up or down by a selectable step and wraps within 0 to 9. A high-priority asynchronous clear forces the digit to zero. A synchronous preset loads a 4-bit value on any clock edge, and a value outside the decimal range is replaced by zero. The held digit is always driven out in binary-coded form and also decoded into segment lines a to g. A parameter flips the segment polarity for common-anode parts.

Top module: `bcd_digit_counter`

## Requirements
- R1: While `rst` is high, `bcd` is 0 and `seg` shows the pattern for 0, without waiting for a clock edge. This holds for as long as `rst` stays high.
- R2: After `rst` falls, the digit can change by counting only on rising edges number `DIV_RATIO`, 2·`DIV_RATIO`, 3·`DIV_RATIO` and so on. The edges are counted from the release of reset. On every other edge without a preset, the digit holds.
- R3: With `count_down` low, a counting edge moves the digit from v to (v + k) mod 10, where k is the effective step.
- R4: With `count_down` high, a counting edge moves the digit from v to (v + 10 − k) mod 10.
- R5: The effective step k is `step_sel` when that value is in 1..9. A `step_sel` of 0 or of 10..15 acts as a step of 1.
- R6: When `preset` is high at a rising edge, the digit takes `load_val` on that edge, whether or not it is a counting edge. Preset wins over counting. `load_val[3]` is the most significant bit.
- R7: A preset with `load_val` above 9 loads 0.
- R8: `bcd` never holds a value above 9.
- R9: With `SEG_ACTIVE_LOW = 0`, `seg[0]` to `seg[6]` drive segments a to g, and a 1 lights a segment. The patterns for digits 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). With `SEG_ACTIVE_LOW = 1`, every bit is inverted.
- R10: A preset does not move the prescaler phase. Counting edges stay on the multiples of `DIV_RATIO` edges after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Board clock |
| rst | input | 1 | Asynchronous clear, active high |
| preset | input | 1 | Synchronous load request |
| load_val | input | 4 | Value to load; bit 3 is the MSB |
| count_down | input | 1 | 1 counts down, 0 counts up |
| step_sel | input | 4 | Count increment, 1..9 |
| bcd | output | 4 | Current digit in binary-coded decimal |
| seg | output | 7 | Segment lines, bit 0 = a through bit 6 = g |

## Verification
Two situations are hard to reach from the ports. The first is a preset that lands exactly on a counting edge; the second is a clear that arrives between clock edges. The bench keeps its own count of edges since reset release. From that count it knows which edges are counting edges, so it holds `preset` across such an edge to show that the load wins and that the next counting edge still falls on the expected multiple. It raises `rst` in the middle of a clock low phase while the digit is non-zero. It then samples the outputs before any further edge and again after an edge with the clear still held.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;
    localparam int RADIX   = 10;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0]   segs_t;

    // Steps outside 1..9 are treated as a step of one.
    function automatic digit_t clamp_step(input digit_t raw);
        if (raw == '0 || raw > digit_t'(RADIX - 1)) begin
            return digit_t'(1);
        end
        return raw;
    endfunction

    // Forces a non-decimal code to zero.
    function automatic digit_t sanitize(input digit_t raw);
        return (raw > digit_t'(RADIX - 1)) ? '0 : raw;
    endfunction

    // Modulo-10 addition of a step.
    function automatic digit_t wrap_up(input digit_t cur, input digit_t k);
        logic [DIGIT_W:0] sum;
        sum = {1'b0, cur} + {1'b0, k};
        if (sum >= (DIGIT_W+1)'(RADIX)) begin
            sum = sum - (DIGIT_W+1)'(RADIX);
        end
        return sum[DIGIT_W-1:0];
    endfunction

    // Modulo-10 subtraction of a step.
    function automatic digit_t wrap_down(input digit_t cur, input digit_t k);
        logic [DIGIT_W:0] diff;
        diff = {1'b0, cur} + (DIGIT_W+1)'(RADIX) - {1'b0, k};
        if (diff >= (DIGIT_W+1)'(RADIX)) begin
            diff = diff - (DIGIT_W+1)'(RADIX);
        end
        return diff[DIGIT_W-1:0];
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV_RATIO = 12_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == LAST);

endmodule

// File: rtl/bcd_step_counter.sv
module bcd_step_counter
    import bcd_cnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   preset,
    input  digit_t load_val,
    input  logic   count_down,
    input  digit_t step_sel,
    output digit_t digit
);
    typedef struct packed {
        digit_t val;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    digit_t     step_k;

    always_comb begin
        st_d   = st_q;
        step_k = clamp_step(step_sel);
        if (preset) begin
            st_d.val = sanitize(load_val);
        end else if (tick) begin
            if (count_down) begin
                st_d.val = wrap_down(st_q.val, step_k);
            end else begin
                st_d.val = wrap_up(st_q.val, step_k);
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign digit = st_q.val;

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
    import bcd_cnt_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  digit_t digit,
    output segs_t  seg
);
    segs_t lit;

    // Bit 0 is segment a, bit 6 is segment g; 1 lights the segment.
    always_comb begin
        case (digit)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
    end

    generate
        if (ACTIVE_LOW) begin : g_anode
            assign seg = ~lit;
        end else begin : g_cathode
            assign seg = lit;
        end
    endgenerate

endmodule

// File: rtl/bcd_digit_counter.sv
module bcd_digit_counter #(
    parameter int CLK_HZ         = 12_000_000,
    parameter int COUNT_HZ       = 1,
    parameter int DIV_RATIO      = CLK_HZ / COUNT_HZ,
    parameter bit SEG_ACTIVE_LOW = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       preset,
    input  logic [3:0] load_val,
    input  logic       count_down,
    input  logic [3:0] step_sel,
    output logic [3:0] bcd,
    output logic [6:0] seg
);
    logic slow_tick;

    tick_prescaler #(.DIV_RATIO(DIV_RATIO)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (slow_tick)
    );

    bcd_step_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (slow_tick),
        .preset     (preset),
        .load_val   (load_val),
        .count_down (count_down),
        .step_sel   (step_sel),
        .digit      (bcd)
    );

    seg_decoder #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_dec (
        .digit (bcd),
        .seg   (seg)
    );

endmodule

// File: rtl/bcd_counter_chk.sv
module bcd_counter_chk #(
    parameter int DIV_RATIO      = 4,
    parameter bit SEG_ACTIVE_LOW = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       preset,
    input logic [3:0] load_val,
    input logic       count_down,
    input logic [3:0] step_sel,
    input logic [3:0] bcd,
    input logic [6:0] seg,
    input logic       tick
);
    localparam logic [6:0] BLANK = SEG_ACTIVE_LOW ? 7'h7F : 7'h00;

    int gap_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            gap_q <= 0;
        end else if (tick) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) rst |-> bcd == 4'd0); // R1

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |-> gap_q == DIV_RATIO - 1); // R2

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
        (!preset && !tick) |=> $stable(bcd)); // R2

    AST_UP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (!preset && tick && !count_down && step_sel == 4'd1)
        |=> bcd == (($past(bcd) == 4'd9) ? 4'd0 : $past(bcd) + 4'd1)); // R3

    AST_DOWN_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (!preset && tick && count_down && step_sel == 4'd1)
        |=> bcd == (($past(bcd) == 4'd0) ? 4'd9 : $past(bcd) - 4'd1)); // R4

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        preset |=> bcd == (($past(load_val) > 4'd9) ? 4'd0 : $past(load_val))); // R6

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        bcd <= 4'd9); // R8

    AST_SEG_LIT: assert property (@(posedge clk) disable iff (rst)
        seg != BLANK); // R9

endmodule

bind bcd_digit_counter bcd_counter_chk #(
    .DIV_RATIO      (DIV_RATIO),
    .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .preset     (preset),
    .load_val   (load_val),
    .count_down (count_down),
    .step_sel   (step_sel),
    .bcd        (bcd),
    .seg        (seg),
    .tick       (slow_tick)
);

// File: tb/sim_bcd_digit_counter.sv
`timescale 1ns/1ps
module sim_bcd_digit_counter;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       preset = 1'b0;
    logic [3:0] load_val = 4'd0;
    logic       count_down = 1'b0;
    logic [3:0] step_sel = 4'd1;
    logic [3:0] bcd;
    logic [6:0] seg;

    int n_checks = 0;
    int n_fail   = 0;
    int edge_cnt = 0;
    int model    = 0;
    bit done     = 1'b0;

    typedef struct {
        int    due;
        int    val;
        string req;
    } exp_t;
    exp_t sb[$];

    bcd_digit_counter #(.DIV_RATIO(DIV)) u0 (
        .clk(clk), .rst(rst), .preset(preset), .load_val(load_val),
        .count_down(count_down), .step_sel(step_sel), .bcd(bcd), .seg(seg)
    );

    always #2.5 clk = ~clk;

    // Edges since reset release.
    always @(posedge clk or posedge rst) begin
        if (rst) edge_cnt <= 0;
        else     edge_cnt <= edge_cnt + 1;
    end

    // Segment patterns taken from R9.
    function automatic logic [6:0] seg_ref(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
            9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compares due items after the edge they belong to.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= edge_cnt) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, int'(bcd), e.val);
            check({e.req, " R9 seg"}, int'(seg), int'(seg_ref(e.val)));
        end
    end

    // Driver: applies one cycle of stimulus, predicts the digit after the next edge.
    task automatic drive(input bit pre, input int ld, input bit dn, input int st,
                         input string req);
        int   e;
        int   k;
        exp_t item;
        preset     = pre;
        load_val   = 4'(ld);
        count_down = dn;
        step_sel   = 4'(st);
        e = edge_cnt + 1;
        k = (st >= 1 && st <= 9) ? st : 1;                  // R5
        if (pre) begin
            model = (ld > 9) ? 0 : ld;                      // R6, R7
        end else if (e % DIV == 0) begin                    // R2, R10
            model = dn ? (model + 10 - k) % 10 : (model + k) % 10;  // R3, R4
        end
        item.due = e;
        item.val = model;
        item.req = req;
        sb.push_back(item);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset bcd", int'(bcd), 0);
        check("R1 reset seg", int'(seg), int'(seg_ref(0)));
        rst = 1'b0;

        // R2 R3: up by one, several wraps
        for (int i = 0; i < 48; i++) drive(0, 0, 0, 1, "R2 R3 up1");
        // R3: up by three
        for (int i = 0; i < 28; i++) drive(0, 0, 0, 3, "R3 up3");
        // R4: down by one across zero
        for (int i = 0; i < 44; i++) drive(0, 0, 1, 1, "R4 down1");
        // R4: down by seven
        for (int i = 0; i < 28; i++) drive(0, 0, 1, 7, "R4 down7");
        // R5: out-of-range steps act as one
        for (int i = 0; i < 12; i++) drive(0, 0, 0, 0, "R5 step0");
        for (int i = 0; i < 12; i++) drive(0, 0, 1, 12, "R5 step12");
        for (int i = 0; i < 12; i++) drive(0, 0, 0, 15, "R5 step15");

        // R6: load on a non-counting edge, MSB position
        while ((edge_cnt + 1) % DIV == 0) drive(0, 0, 0, 1, "R2 align");
        drive(1, 7, 0, 1, "R6 load7");
        drive(0, 0, 0, 1, "R6 after");
        drive(1, 8, 0, 1, "R6 msb");
        // R7: non-decimal loads become zero
        drive(1, 13, 0, 1, "R7 load13");
        drive(1, 6, 0, 1, "R6 load6");
        drive(1, 15, 0, 1, "R7 load15");
        // R6 R10: preset held across a counting edge
        while ((edge_cnt + 2) % DIV != 0) drive(0, 0, 0, 1, "R2 align");
        drive(1, 5, 0, 9, "R6 pre before tick");
        drive(1, 5, 0, 9, "R6 pre on tick");
        for (int i = 0; i < 16; i++) drive(0, 0, 0, 9, "R10 phase up9");
        // R8: extremes with a large step
        drive(1, 9, 0, 9, "R8 load9");
        for (int i = 0; i < 20; i++) drive(0, 0, 0, 9, "R8 up9");
        drive(1, 0, 1, 9, "R8 load0");
        for (int i = 0; i < 20; i++) drive(0, 0, 1, 9, "R8 down9");

        // R1: asynchronous clear mid-cycle with a non-zero digit
        drive(1, 4, 0, 1, "R1 setup");
        preset = 1'b0;
        sb.delete();
        #1 rst = 1'b1;
        #0.5;
        check("R1 async bcd", int'(bcd), 0);
        check("R1 async seg", int'(seg), int'(seg_ref(0)));
        @(posedge clk);
        #1;
        check("R1 held bcd", int'(bcd), 0);
        @(negedge clk);
        rst = 1'b0;
        model = 0;
        for (int i = 0; i < 16; i++) drive(0, 0, 0, 2, "R2 R3 after clear");

        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule